// File: doc/BRIEF.md
# HDLC Receive Buffer Descriptor Engine

This block takes the octet stream produced by an HDLC deframer (one strobe per received byte, a marker on the first byte of each frame, and a separate end-of-frame strobe that carries six error flags) and stores the bytes in memory buffers. The buffers are described by a ring of 8-byte descriptors held in a shared RAM. Each descriptor has a 16-bit status word at offset 0, a 16-bit length at offset 2, and a 32-bit buffer address at offset 4 (upper half) and offset 6 (lower half). Only the descriptor that holds the wrap flag sets the size of the ring.

Software hands a descriptor to the engine by setting its empty flag. The engine reads the descriptor, fills the buffer up to a programmable buffer size and then closes it. To close a buffer it writes the length word and, one cycle later, the status word with the empty flag cleared. The status word also carries first-of-frame, last-of-frame and error bits. A frame that does not fit in one buffer continues in the next descriptor. A frame that finds no free descriptor is flagged as an overrun and its remaining bytes are dropped. One-cycle event pulses report a finished buffer, a finished frame and an overrun.

The memory port is a simple synchronous RAM port with 16-bit words, byte addresses and byte-lane enables. Read data is returned one cycle after the request. There is no arbitration.

Top module: `rxbd_engine`

## Requirements
- R1: After reset the engine makes no memory access and raises no event until a byte arrives, and the first descriptor it uses is the one at `ring_base`.
- R2: Each accepted data byte is written to buffer address plus byte index within the buffer. An even address uses `mem_be`=2'b10 and an odd address uses 2'b01, with the byte copied onto both halves of `mem_wdata`.
- R3: Descriptors are 8 bytes apart. The status word is at +0, the length at +2, and the buffer address is read from +4 (upper 16 bits) then +6 (lower 16 bits).
- R4: A buffer is closed by writing its length word and then, in the very next cycle, its status word with bit 15 (empty) cleared. No other write to that descriptor follows the status write.
- R5: When a frame ends, the buffer holding its final byte gets bit 11 (last) set and a length equal to the total number of octets in the frame.
- R6: Bit 10 (first) is set only in the buffer that received the frame's first byte.
- R7: When a buffer already holds `buf_size` bytes and another byte of the same frame arrives, that buffer is closed with bit 11 clear and length `buf_size`, and the byte goes to the next descriptor.
- R8: Bit 13 (wrap) and bit 12 (interrupt) are kept in the written-back status. After a descriptor with bit 13 set, the next descriptor is `ring_base`; otherwise it is the current address plus 8.
- R9: `evt_rxf` pulses for one cycle with every status write that has bit 11 set, whatever bit 12 holds. `evt_rxb` pulses with a status write that has bit 11 clear only if bit 12 is set.
- R10: Bits 5..0 of a last buffer's status equal `end_errs` (5 too long, 4 not octet aligned, 3 abort, 2 CRC, 1 overrun, 0 carrier lost). Bits 14 and 9..6 are written as zero, and a buffer that is not last has bits 5..0 clear.
- R11: A frame's first byte that finds the current descriptor with bit 15 clear causes no write and one `evt_ovr` pulse, and the frame is dropped. The descriptor pointer does not move, so the next frame tries the same descriptor again.
- R12: If the next descriptor has bit 15 clear when a frame must continue into it, the current buffer is closed as last, with bit 1 (overrun) set and the frame count so far as its length. `evt_ovr` and then `evt_rxf` pulse, and the frame's remaining bytes and its end strobe are ignored.
- R13: An end-of-frame strobe while no frame is being stored causes no write and no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | ADDR_W | Byte address of the first descriptor |
| buf_size | input | 16 | Maximum bytes per buffer (at least 1) |
| in_valid | input | 1 | Received byte strobe |
| in_byte | input | 8 | Received byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| end_valid | input | 1 | End-of-frame strobe |
| end_errs | input | 6 | Error flags reported with the end strobe |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | ADDR_W | Byte address |
| mem_be | output | 2 | Byte lanes: bit 1 even byte [15:8], bit 0 odd byte [7:0] |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| evt_rxb | output | 1 | Buffer finished (not last, interrupt bit set) |
| evt_rxf | output | 1 | Frame finished (last buffer written back) |
| evt_ovr | output | 1 | Frame data lost because no descriptor was free |

## Verification
The assertions assume that the deframer never raises a byte strobe and an end strobe in the same cycle. They also assume that no strobe arrives while the previous one is still held in the single-entry intake stage, because the engine handles one event at a time and that event can need up to nine cycles when it chains into a new descriptor. The bench keeps to this by spacing every strobe fourteen clocks apart. It uses a `buf_size` of at least one, keeps descriptors 8-byte aligned, and changes descriptor words only between frames while the engine is idle.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

  // Status word bit positions (decoded by software)
  localparam int ST_EMPTY = 15;
  localparam int ST_WRAP  = 13;
  localparam int ST_INTR  = 12;
  localparam int ST_LAST  = 11;
  localparam int ST_FIRST = 10;
  localparam int ERR_W    = 6;
  localparam int LEN_W    = 16;
  localparam logic [ERR_W-1:0] ERR_OVERRUN = 6'b000010;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_RD_ST, SQ_CHK_ST, SQ_WR_LEN, SQ_WR_ST,
    SQ_RD_PH, SQ_RD_PL, SQ_CAP_PL, SQ_WR_DATA
  } sq_state_e;

  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WORD, OP_BYTE} mem_op_e;

  // Build the written-back status word: empty cleared, reserved zero
  function automatic logic [15:0] desc_status(input logic wrap, input logic intr,
                                              input logic last, input logic first,
                                              input logic [ERR_W-1:0] errs);
    logic [15:0] w;
    w = '0;
    w[ST_WRAP]  = wrap;
    w[ST_INTR]  = intr;
    w[ST_LAST]  = last;
    w[ST_FIRST] = first;
    w[ERR_W-1:0] = errs;
    return w;
  endfunction

  // Big-endian lane select: even address -> upper byte
  function automatic logic [1:0] lane_enable(input logic odd);
    return odd ? 2'b01 : 2'b10;
  endfunction

endpackage

// File: rtl/rxbd_ingress.sv
module rxbd_ingress
  import rxbd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_sof,
  input  logic             end_valid,
  input  logic [ERR_W-1:0] end_errs,
  input  logic             consume,
  output logic             pend,
  output logic             pend_end,
  output logic             pend_first,
  output logic [7:0]       pend_byte,
  output logic [ERR_W-1:0] pend_errs
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      pend_end   <= 1'b0;
      pend_first <= 1'b0;
      pend_byte  <= '0;
      pend_errs  <= '0;
    end else if (!pend) begin
      if (in_valid || end_valid) begin
        pend       <= 1'b1;
        pend_end   <= end_valid;
        pend_first <= in_sof && !end_valid;
        pend_byte  <= in_byte;
        pend_errs  <= end_errs;
      end
    end else if (consume) begin
      pend <= 1'b0;
    end
  end

endmodule

// File: rtl/rxbd_seq.sv
module rxbd_seq
  import rxbd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [LEN_W-1:0]  buf_size,
  input  logic              pend,
  input  logic              pend_end,
  input  logic              pend_first,
  input  logic [7:0]        pend_byte,
  input  logic [ERR_W-1:0]  pend_errs,
  input  logic [15:0]       mem_rdata,
  output logic              consume,
  output mem_op_e           op,
  output logic [ADDR_W-1:0] op_addr,
  output logic [15:0]       op_word,
  output logic [7:0]        op_byte,
  output logic              evt_rxb,
  output logic              evt_rxf,
  output logic              evt_ovr,
  output logic              tap_len,
  output logic              tap_stat,
  output logic              tap_data
);

  localparam logic [ADDR_W-1:0] OFS_LEN = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_PHI = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_PLO = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] STRIDE  = ADDR_W'(8);

  sq_state_e         state;
  logic [ADDR_W-1:0] cur_bd, peek_q, ptr;
  logic [15:0]       ptr_hi;
  logic [LEN_W-1:0]  buf_cnt, frm_cnt;
  logic              at_start, open_q, discard_q, chain_q;
  logic              cur_w, cur_i, nxt_w, nxt_i, cur_first, close_last;
  logic [ERR_W-1:0]  close_errs;
  logic [ADDR_W-1:0] desc_now;
  logic              idle_drop, idle_close;

  function automatic logic [ADDR_W-1:0] next_of(input logic [ADDR_W-1:0] cur,
                                                input logic [ADDR_W-1:0] base,
                                                input logic wrap);
    return wrap ? base : cur + STRIDE;
  endfunction

  function automatic logic [ADDR_W-1:0] join_ptr(input logic [15:0] hi, input logic [15:0] lo);
    logic [31:0] full;
    full = {hi, lo};
    return full[ADDR_W-1:0];
  endfunction

  assign desc_now   = at_start ? ring_base : cur_bd;
  assign idle_close = pend && pend_end && open_q;
  assign idle_drop  = pend && ((pend_end && !open_q) ||
                               (!pend_end && !pend_first && (discard_q || !open_q)));

  // Memory command and event decode
  always_comb begin
    op       = OP_NONE;
    op_addr  = desc_now;
    op_word  = '0;
    op_byte  = pend_byte;
    consume  = 1'b0;
    evt_rxb  = 1'b0;
    evt_rxf  = 1'b0;
    evt_ovr  = 1'b0;
    tap_len  = 1'b0;
    tap_stat = 1'b0;
    tap_data = 1'b0;
    unique case (state)
      SQ_IDLE:   consume = idle_drop || idle_close;
      SQ_RD_ST: begin
        op      = OP_READ;
        op_addr = peek_q;
      end
      SQ_CHK_ST: begin
        if (!mem_rdata[ST_EMPTY]) begin
          evt_ovr = 1'b1;
          consume = 1'b1;
        end
      end
      SQ_WR_LEN: begin
        op      = OP_WORD;
        op_addr = desc_now + OFS_LEN;
        op_word = close_last ? frm_cnt : buf_cnt;
        tap_len = 1'b1;
      end
      SQ_WR_ST: begin
        op       = OP_WORD;
        op_word  = desc_status(cur_w, cur_i, close_last, cur_first, close_errs);
        evt_rxf  = close_last;
        evt_rxb  = !close_last && cur_i;
        tap_stat = 1'b1;
      end
      SQ_RD_PH: begin
        op      = OP_READ;
        op_addr = desc_now + OFS_PHI;
      end
      SQ_RD_PL: begin
        op      = OP_READ;
        op_addr = desc_now + OFS_PLO;
      end
      SQ_WR_DATA: begin
        op       = OP_BYTE;
        op_addr  = ptr + ADDR_W'(buf_cnt);
        consume  = 1'b1;
        tap_data = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      cur_bd     <= '0;
      peek_q     <= '0;
      ptr        <= '0;
      ptr_hi     <= '0;
      buf_cnt    <= '0;
      frm_cnt    <= '0;
      at_start   <= 1'b1;
      open_q     <= 1'b0;
      discard_q  <= 1'b0;
      chain_q    <= 1'b0;
      cur_w      <= 1'b0;
      cur_i      <= 1'b0;
      nxt_w      <= 1'b0;
      nxt_i      <= 1'b0;
      cur_first  <= 1'b0;
      close_last <= 1'b0;
      close_errs <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (pend && !idle_drop) begin
            if (idle_close) begin
              close_last <= 1'b1;
              close_errs <= pend_errs;
              chain_q    <= 1'b0;
              state      <= SQ_WR_LEN;
            end else if (pend_first) begin
              discard_q <= 1'b0;
              peek_q    <= desc_now;
              state     <= SQ_RD_ST;
            end else if (buf_cnt < buf_size) begin
              state <= SQ_WR_DATA;
            end else begin
              peek_q <= next_of(desc_now, ring_base, cur_w);
              state  <= SQ_RD_ST;
            end
          end
        end
        SQ_RD_ST: state <= SQ_CHK_ST;
        SQ_CHK_ST: begin
          nxt_w <= mem_rdata[ST_WRAP];
          nxt_i <= mem_rdata[ST_INTR];
          if (mem_rdata[ST_EMPTY]) begin
            if (open_q) begin
              close_last <= 1'b0;
              close_errs <= '0;
              chain_q    <= 1'b1;
              state      <= SQ_WR_LEN;
            end else begin
              state <= SQ_RD_PH;
            end
          end else begin
            discard_q <= 1'b1;
            if (open_q) begin
              close_last <= 1'b1;
              close_errs <= ERR_OVERRUN;
              chain_q    <= 1'b0;
              state      <= SQ_WR_LEN;
            end else begin
              state <= SQ_IDLE;
            end
          end
        end
        SQ_WR_LEN: state <= SQ_WR_ST;
        SQ_WR_ST: begin
          cur_bd   <= next_of(desc_now, ring_base, cur_w);
          at_start <= 1'b0;
          open_q   <= 1'b0;
          state    <= chain_q ? SQ_RD_PH : SQ_IDLE;
        end
        SQ_RD_PH: begin
          cur_w     <= nxt_w;
          cur_i     <= nxt_i;
          cur_first <= pend_first;
          state     <= SQ_RD_PL;
        end
        SQ_RD_PL: begin
          ptr_hi <= mem_rdata;
          state  <= SQ_CAP_PL;
        end
        SQ_CAP_PL: begin
          ptr     <= join_ptr(ptr_hi, mem_rdata);
          open_q  <= 1'b1;
          buf_cnt <= '0;
          if (pend_first) frm_cnt <= '0;
          state   <= SQ_WR_DATA;
        end
        SQ_WR_DATA: begin
          buf_cnt <= buf_cnt + 1'b1;
          frm_cnt <= frm_cnt + 1'b1;
          state   <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rxbd_memport.sv
module rxbd_memport
  import rxbd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  mem_op_e           op,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [15:0]       op_word,
  input  logic [7:0]        op_byte,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata
);

  always_comb begin
    mem_en    = (op != OP_NONE);
    mem_we    = (op == OP_WORD) || (op == OP_BYTE);
    mem_addr  = op_addr;
    mem_be    = (op == OP_BYTE) ? lane_enable(op_addr[0]) : 2'b11;
    mem_wdata = (op == OP_BYTE) ? {op_byte, op_byte} : op_word;
  end

endmodule

// File: rtl/rxbd_engine.sv
module rxbd_engine
  import rxbd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [15:0]       buf_size,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  input  logic              in_sof,
  input  logic              end_valid,
  input  logic [5:0]        end_errs,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_be,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata,
  output logic              evt_rxb,
  output logic              evt_rxf,
  output logic              evt_ovr
);

  logic              pend, pend_end, pend_first, consume;
  logic [7:0]        pend_byte;
  logic [ERR_W-1:0]  pend_errs;
  mem_op_e           op;
  logic [ADDR_W-1:0] op_addr;
  logic [15:0]       op_word;
  logic [7:0]        op_byte;
  // Observation wires for the checker
  logic              tap_len, tap_stat, tap_data;

  rxbd_ingress u_ingress (
    .clk, .rst_n, .in_valid, .in_byte, .in_sof, .end_valid, .end_errs,
    .consume, .pend, .pend_end, .pend_first, .pend_byte, .pend_errs
  );

  rxbd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk, .rst_n, .ring_base, .buf_size, .pend, .pend_end, .pend_first,
    .pend_byte, .pend_errs, .mem_rdata, .consume, .op, .op_addr, .op_word,
    .op_byte, .evt_rxb, .evt_rxf, .evt_ovr, .tap_len, .tap_stat, .tap_data
  );

  rxbd_memport #(.ADDR_W(ADDR_W)) u_memport (
    .op, .op_addr, .op_word, .op_byte,
    .mem_en, .mem_we, .mem_addr, .mem_be, .mem_wdata
  );

endmodule

// File: rtl/rxbd_engine_chk.sv
module rxbd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] buf_size,
  input logic        in_valid,
  input logic        end_valid,
  input logic        pend,
  input logic        mem_en,
  input logic        mem_we,
  input logic [1:0]  mem_be,
  input logic [15:0] mem_wdata,
  input logic        evt_rxb,
  input logic        evt_rxf,
  input logic        evt_ovr,
  input logic        tap_len,
  input logic        tap_stat,
  input logic        tap_data
);

  AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n) !(in_valid && end_valid)); // R13
  AST_INTAKE_FREE: assert property (@(posedge clk) disable iff (!rst_n) (in_valid || end_valid) |-> !pend); // R2
  AST_DATA_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n) tap_data |-> (mem_en && mem_we && $countones(mem_be) == 1 && mem_wdata[15:8] == mem_wdata[7:0])); // R2
  AST_STATUS_AFTER_LEN: assert property (@(posedge clk) disable iff (!rst_n) tap_stat |-> $past(tap_len)); // R4
  AST_LEN_THEN_STATUS: assert property (@(posedge clk) disable iff (!rst_n) tap_len |=> tap_stat); // R4
  AST_EMPTY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) tap_stat |-> (mem_we && !mem_wdata[15])); // R4
  AST_SPLIT_LEN: assert property (@(posedge clk) disable iff (!rst_n) (tap_stat && !mem_wdata[11]) |-> ($past(mem_wdata) == buf_size)); // R7
  AST_RXF_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n) evt_rxf |-> (tap_stat && mem_wdata[11])); // R9
  AST_RXB_ON_INTR: assert property (@(posedge clk) disable iff (!rst_n) evt_rxb |-> (tap_stat && !mem_wdata[11] && mem_wdata[12])); // R9
  AST_EVENTS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({evt_rxb, evt_rxf, evt_ovr})); // R9
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) tap_stat |-> (mem_wdata[14] == 1'b0 && mem_wdata[9:6] == 4'b0)); // R10
  AST_ERRS_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n) (tap_stat && !mem_wdata[11]) |-> (mem_wdata[5:0] == 6'b0)); // R10
  AST_OVR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) evt_ovr |-> !mem_en); // R11

endmodule

bind rxbd_engine rxbd_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .buf_size(buf_size), .in_valid(in_valid),
  .end_valid(end_valid), .pend(pend), .mem_en(mem_en), .mem_we(mem_we),
  .mem_be(mem_be), .mem_wdata(mem_wdata), .evt_rxb(evt_rxb), .evt_rxf(evt_rxf),
  .evt_ovr(evt_ovr), .tap_len(tap_len), .tap_stat(tap_stat), .tap_data(tap_data)
);

// File: tb/rxbd_engine_tb_top.sv
`timescale 1ns/1ps
module rxbd_engine_tb_top;

  localparam int GAP = 14;
  localparam logic [15:0] BASE = 16'h0100;
  localparam logic [15:0] BUFSZ = 16'd8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, end_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic [5:0] end_errs = '0;
  logic mem_en, mem_we, evt_rxb, evt_rxf, evt_ovr;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic [1:0] mem_be;

  always #2.5 clk = ~clk;

  rxbd_engine #(.ADDR_W(16)) dut_i (
    .clk, .rst_n, .ring_base(BASE), .buf_size(BUFSZ), .in_valid, .in_byte,
    .in_sof, .end_valid, .end_errs, .mem_en, .mem_we, .mem_addr, .mem_be,
    .mem_wdata, .mem_rdata, .evt_rxb, .evt_rxf, .evt_ovr
  );

  // RAM model, one-cycle read latency
  logic [15:0] ram [0:1023];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        if (mem_be[1]) ram[mem_addr[10:1]][15:8] <= mem_wdata[15:8];
        if (mem_be[0]) ram[mem_addr[10:1]][7:0]  <= mem_wdata[7:0];
      end else begin
        mem_rdata <= ram[mem_addr[10:1]];
      end
    end
  end

  int n_chk = 0, n_err = 0;
  int n_wr = 0, n_rxb = 0, n_rxf = 0, n_ovr = 0;

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model: expected write stream and event stream
  typedef struct { logic [15:0] a; logic [1:0] be; logic [15:0] d; string tag; } wr_t;
  wr_t exp_wr[$];
  int  exp_ev[$];  // 0 buffer, 1 frame, 2 overrun

  logic [15:0] m_cur = BASE, m_ptr;
  bit m_open = 0, m_disc = 0, m_w, m_i, m_first;
  int m_buf, m_frm;

  function automatic logic [15:0] rd16(input logic [15:0] a);
    return ram[a[10:1]];
  endfunction

  task automatic push_wr(input logic [15:0] a, input logic [1:0] be, input logic [15:0] d, input string tag);
    wr_t e;
    e.a = a; e.be = be; e.d = d; e.tag = tag;
    exp_wr.push_back(e);
  endtask

  task automatic m_data(input logic [7:0] b);
    logic [15:0] a;
    a = m_ptr + 16'(m_buf);
    push_wr(a, a[0] ? 2'b01 : 2'b10, {b, b}, "R2 data byte");
    m_buf++; m_frm++;
  endtask

  task automatic m_close(input bit last, input logic [5:0] errs);
    logic [15:0] st;
    st = (16'(m_w) << 13) | (16'(m_i) << 12) | (16'(last) << 11) | (16'(m_first) << 10) | 16'(errs);
    push_wr(m_cur + 16'd2, 2'b11, last ? 16'(m_frm) : 16'(m_buf), last ? "R5 length" : "R7 length");
    push_wr(m_cur, 2'b11, st, "R4 status");
    if (last) exp_ev.push_back(1);
    else if (m_i) exp_ev.push_back(0);
    m_cur = m_w ? BASE : m_cur + 16'd8;
  endtask

  task automatic m_load(input bit first);
    logic [15:0] st;
    st = rd16(m_cur);
    m_w = st[13]; m_i = st[12];
    m_ptr = rd16(m_cur + 16'd6);
    m_open = 1; m_first = first; m_buf = 0;
    if (first) m_frm = 0;
  endtask

  task automatic model_byte(input bit first, input logic [7:0] b);
    logic [15:0] nxt;
    if (first) begin
      m_disc = 0;
      if (!rd16(m_cur)[15]) begin exp_ev.push_back(2); m_disc = 1; return; end
      m_load(1); m_data(b);
    end else if (!m_disc && m_open) begin
      if (m_buf < int'(BUFSZ)) m_data(b);
      else begin
        nxt = m_w ? BASE : m_cur + 16'd8;
        if (rd16(nxt)[15]) begin m_close(0, 6'd0); m_load(0); m_data(b); end
        else begin exp_ev.push_back(2); m_close(1, 6'b000010); m_open = 0; m_disc = 1; end
      end
    end
  endtask

  task automatic model_end(input logic [5:0] errs);
    if (m_open) begin m_close(1, errs); m_open = 0; end
  endtask

  // Compare on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_en && mem_we) begin
        wr_t e;
        n_wr++;
        if (exp_wr.size() == 0) chk("R4 unexpected write", {mem_addr, 14'd0, mem_be, mem_wdata}, 48'd0);
        else begin
          e = exp_wr.pop_front();
          chk(e.tag, {mem_addr, 14'd0, mem_be, mem_wdata}, {e.a, 14'd0, e.be, e.d});
        end
      end
      if (evt_rxb || evt_rxf || evt_ovr) begin
        int k;
        k = evt_ovr ? 2 : (evt_rxf ? 1 : 0);
        if (evt_rxb) n_rxb++;
        if (evt_rxf) n_rxf++;
        if (evt_ovr) n_ovr++;
        if (exp_ev.size() == 0) chk("R9 unexpected event", 48'(k), 48'hFF);
        else chk("R9 event kind", 48'(k), 48'(exp_ev.pop_front()));
      end
    end
  end

  task automatic send_byte(input bit first, input logic [7:0] b);
    @(negedge clk);
    model_byte(first, b);
    in_valid = 1; in_sof = first; in_byte = b;
    @(negedge clk);
    in_valid = 0; in_sof = 0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic send_end(input logic [5:0] e);
    @(negedge clk);
    model_end(e);
    end_valid = 1; end_errs = e;
    @(negedge clk);
    end_valid = 0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic send_frame(input int n, input logic [7:0] v0, input logic [5:0] e);
    for (int k = 0; k < n; k++) send_byte(k == 0, v0 + 8'(k));
    send_end(e);
  endtask

  function automatic logic [15:0] dsc(input int i, input int ofs);
    return rd16(BASE + 16'(8 * i + ofs));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int w0;
    for (int k = 0; k < 1024; k++) ram[k] = '0;
    for (int i = 0; i < 4; i++) ram[(BASE + 16'(8 * i + 6)) >> 1] = 16'h0200 + 16'(64 * i);
    ram[(BASE + 0) >> 1]  = 16'h9000;
    ram[(BASE + 8) >> 1]  = 16'h9000;
    ram[(BASE + 16) >> 1] = 16'h8000;
    ram[(BASE + 24) >> 1] = 16'hB000;
    repeat (4) @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R1 idle after reset", {mem_en, evt_rxb, evt_rxf, evt_ovr}, 48'd0);
    end

    // Single-buffer frame into the descriptor at the ring base
    send_frame(5, 8'hA0, 6'd0);
    chk("R1 R5 R6 first descriptor status", dsc(0, 0), 16'h1C00);
    chk("R5 frame length", dsc(0, 2), 16'd5);
    chk("R2 even-odd byte pair", rd16(16'h0200), 16'hA0A1);
    chk("R2 lone even byte", rd16(16'h0204), 16'hA400);

    // 20-byte frame spread over three descriptors, the last one wraps
    send_frame(20, 8'hB0, 6'd0);
    chk("R6 R7 split buffer status", dsc(1, 0), 16'h1400);
    chk("R7 split buffer length", dsc(1, 2), 16'd8);
    chk("R6 middle buffer status", dsc(2, 0), 16'h0000);
    chk("R8 wrap kept in last status", dsc(3, 0), 16'h3800);
    chk("R5 total frame length", dsc(3, 2), 16'd20);
    chk("R3 pointer from +4/+6", rd16(16'h02C0), 16'hC0C1);
    chk("R9 buffer events with bit 12", n_rxb, 1);
    chk("R9 frame events", n_rxf, 2);

    // Base descriptor not handed back: frame dropped
    send_frame(3, 8'h30, 6'b001000);
    chk("R11 overrun event", n_ovr, 1);
    chk("R11 descriptor untouched", dsc(0, 0), 16'h1C00);

    // Re-arm and retry the same descriptor, with an error end
    ram[BASE >> 1] = 16'h9000;
    send_frame(3, 8'hD0, 6'b000100);
    chk("R10 error bits in last status", dsc(0, 0), 16'h1C04);
    chk("R8 R11 wrapped reuse of base buffer", rd16(16'h0200), 16'hD0D1);

    // End strobe with no frame open
    w0 = n_wr;
    send_end(6'b000001);
    chk("R13 no write on stray end", n_wr, w0);
    chk("R13 no frame event", n_rxf, 3);

    // Continuation blocked by a descriptor still owned by software
    ram[(BASE + 8) >> 1] = 16'h9000;
    send_frame(11, 8'h50, 6'd0);
    chk("R12 closed as last with overrun", dsc(1, 0), 16'h1C02);
    chk("R12 length so far", dsc(1, 2), 16'd8);
    chk("R12 overrun event", n_ovr, 2);
    chk("R12 frame event", n_rxf, 4);
    chk("R12 blocked buffer keeps old data", rd16(16'h0280), 16'hB8B9);

    // Stall on the same descriptor, then retry after re-arming
    send_frame(2, 8'h70, 6'd0);
    chk("R11 stall repeats overrun", n_ovr, 3);
    ram[(BASE + 16) >> 1] = 16'h8000;
    send_frame(2, 8'h60, 6'd0);
    chk("R11 retried descriptor status", dsc(2, 0), 16'h0C00);
    chk("R11 retried descriptor length", dsc(2, 2), 16'd2);
    chk("R9 no buffer event without bit 12", n_rxb, 1);

    repeat (10) @(negedge clk);
    chk("R4 all expected writes seen", exp_wr.size(), 0);
    chk("R9 all expected events seen", exp_ev.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule